// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces horizontal sync, vertical sync, an active-video strobe and the current scan position for a progressive raster display. All timing is read from run-time control words loaded through a simple write port: the line period and horizontal pulse width share one word, the frame length in lines has its own word, and a third word holds the vertical pulse width, the two sync polarity bits and the unit bit for the vertical pulse. The start of active video is given as wait counts measured from the leading edge of each sync pulse. The size of the active area comes from a transfer-count word.

The raster advances on a pixel enable made inside the block. The master clock is divided by a programmable integer, and a gate bit can stop the enable. The geometry words go to shadow copies. The counters only use those copies when a frame wraps, so a frame always uses one consistent set of timing values. The divider word takes effect as soon as it is written.

A vertical phase state machine tracks the position of the coming line within the frame. Its states are VS_PULSE (the line lies inside a line-counted vertical pulse and before the vertical wait ends), VS_WAIT (the rest of the vertical wait), VS_ACTIVE (the line is inside the active line range) and VS_TAIL (lines after the active range, up to the frame end). The machine has two transitions. On LINE_STEP, at the last pixel of a line, it moves to the phase of the next line using the current timing. On FRAME_WRAP, at the last pixel of the last line, it moves to the phase of line 0 using the shadow timing that is loaded at that edge. Reset places it in the phase of line 0 of the reset timing.

Top module: `rtg_top`

## Requirements
- R1: The pixel counter `pos_x` steps once per pixel enable from 0 up to HPER-1. It then returns to 0 and the line counter advances. HPER is bits 15:0 of the word at address 0.
- R2: `hsync` is asserted while `pos_x` < HWID, where HWID is bits 31:24 of address 0. Bit 16 of address 2 selects the polarity: 0 drives the asserted level low and 1 drives it high.
- R3: The line counter `pos_y` runs from 0 up to VPER-1 and then wraps to 0, which starts a new frame. VPER is bits 15:0 of address 1 and counts lines.
- R4: When bit 18 of address 2 is 1, the vertical pulse is counted in lines. `vsync` is asserted while `pos_y` < VWID, where VWID is bits 15:0 of address 2. It only changes on a line's first pixel (`pos_x` = 0). Bit 17 of address 2 selects its polarity in the same way as bit 16 does for `hsync`.
- R5: When bit 18 of address 2 is 0, `vsync` is asserted for the first VWID pixel enables of each frame, counted from pixel 0 of line 0.
- R6: `active` is high only when HWAIT <= `pos_x` < HWAIT+NPIX and VWAIT <= `pos_y` < VWAIT+NLINE. HWAIT is bits 31:16 and VWAIT is bits 15:0 of address 3. NLINE is bits 31:16 and NPIX is bits 15:0 of address 4.
- R7: A write to addresses 0 to 4 does not change the outputs of the current frame. It takes effect from pixel 0 of the next frame.
- R8: Bits 7:0 of address 5 set the divider N. For N of 0 or 1, `pix_ce` is high on every master clock. For larger N, `pix_ce` is high once every N master clocks. A write to address 5 restarts the divider phase.
- R9: When bit 31 of address 5 is 1, `pix_ce` stays low and `pos_x`, `pos_y` and the sync outputs hold their values.
- R10: After reset, `pos_x` and `pos_y` are 0 and the timing, divider and gate take their parameter defaults. The outputs show pixel 0 of line 0 under that timing.
- R11: Writes to addresses 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel enable from the divider |
| hsync | output | 1 | Horizontal sync, polarity from register |
| vsync | output | 1 | Vertical sync, polarity from register |
| active | output | 1 | Active-video window strobe |
| pos_x | output | 16 | Pixel position within the line |
| pos_y | output | 16 | Line position within the frame |

## Verification
A behavioural model in the bench follows the register map and is compared with every output on every cycle. The run starts with a small reset timing, so that wrong line length, pulse widths or window bounds show up as mismatched counts over a whole frame. The bench then switches the vertical pulse to pixel units to tell it apart from the line-counted pulse. It changes the divider to 3 and to 0 to separate the divided and pass-through enables, and sets the gate to show that the raster freezes. A mid-line write of polarity and line length shows whether new timing leaks into the running frame or waits for the wrap. Writes to the unused addresses must leave the model comparison clean.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    parameter int unsigned CNT_W  = 16;  // counter and field width, at most 16
    parameter int unsigned HWID_W = 8;   // horizontal pulse width field
    parameter int unsigned DIV_W  = 8;   // divider field
    parameter int unsigned ADDR_W = 3;
    parameter int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_HTIME = 3'd0;
    localparam logic [ADDR_W-1:0] A_VTIME = 3'd1;
    localparam logic [ADDR_W-1:0] A_SYNC  = 3'd2;
    localparam logic [ADDR_W-1:0] A_WAIT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_AREA  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLK   = 3'd5;

    typedef struct packed {
        logic [CNT_W-1:0]  hper;
        logic [HWID_W-1:0] hwid;
        logic [CNT_W-1:0]  vper;
        logic [CNT_W-1:0]  vwid;
        logic              hpol;
        logic              vpol;
        logic              vunit;
        logic [CNT_W-1:0]  hwait;
        logic [CNT_W-1:0]  vwait;
        logic [CNT_W-1:0]  npix;
        logic [CNT_W-1:0]  nline;
    } tcfg_t;

    typedef enum logic [1:0] {
        VS_PULSE  = 2'd0,
        VS_WAIT   = 2'd1,
        VS_ACTIVE = 2'd2,
        VS_TAIL   = 2'd3
    } vphase_e;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter tcfg_t            RST_CFG  = '0,
    parameter logic [DIV_W-1:0] RST_DIV  = '0,
    parameter logic             RST_GATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output tcfg_t             shadow,
    output tcfg_t             work,
    output logic [DIV_W-1:0]  div_q,
    output logic              gate_q,
    output logic              div_wr
);

    assign div_wr = we && (addr == A_CLK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= RST_CFG;
            div_q  <= RST_DIV;
            gate_q <= RST_GATE;
        end else if (we) begin
            case (addr)
                A_HTIME: begin
                    shadow.hwid <= wdata[31 -: HWID_W];
                    shadow.hper <= wdata[CNT_W-1:0];
                end
                A_VTIME: shadow.vper <= wdata[CNT_W-1:0];
                A_SYNC: begin
                    shadow.vwid  <= wdata[CNT_W-1:0];
                    shadow.hpol  <= wdata[16];
                    shadow.vpol  <= wdata[17];
                    shadow.vunit <= wdata[18];
                end
                A_WAIT: begin
                    shadow.hwait <= wdata[16 +: CNT_W];
                    shadow.vwait <= wdata[CNT_W-1:0];
                end
                A_AREA: begin
                    shadow.nline <= wdata[16 +: CNT_W];
                    shadow.npix  <= wdata[CNT_W-1:0];
                end
                A_CLK: begin
                    div_q  <= wdata[DIV_W-1:0];
                    gate_q <= wdata[31];
                end
                default: ;
            endcase
        end
    end

    // working copy follows the shadow only at a frame wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    work <= RST_CFG;
        else if (load) work <= shadow;
    end

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(work));

endmodule

// File: rtl/rtg_clkdiv.sv
module rtg_clkdiv
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    input  logic             gate_q,
    input  logic             restart,
    output logic             pix_ce
);

    logic [DIV_W-1:0] cnt;
    logic             bypass;

    assign bypass = (div_q <= DIV_W'(1));
    assign pix_ce = !gate_q && (bypass || (cnt == div_q - 1'b1));

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (restart)           cnt <= '0;
        else if (gate_q || bypass)  cnt <= '0;
        else if (cnt == div_q - 1'b1) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assert_ce_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q > DIV_W'(1) && pix_ce && !restart) |=> !pix_ce);

endmodule

// File: rtl/rtg_raster.sv
module rtg_raster
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce,
    input  tcfg_t            cfg,
    input  tcfg_t            nxt,
    output logic             frame_wrap,
    output logic [CNT_W-1:0] hc_o,
    output logic [CNT_W-1:0] vc_o,
    output logic             hsync,
    output logic             vsync,
    output logic             active
);

    logic [CNT_W-1:0] hc, vc, vpx;
    logic             line_end;
    vphase_e          st_q, st_d;
    logic             hs_raw, vs_raw, hwin;

    function automatic vphase_e phase_of(input logic [CNT_W-1:0] line, input tcfg_t c);
        logic [CNT_W:0] stop;
        vphase_e        ph;
        stop = {1'b0, c.vwait} + {1'b0, c.nline};
        if (line < c.vwait)
            ph = (c.vunit && line < c.vwid) ? VS_PULSE : VS_WAIT;
        else if ({1'b0, line} < stop)
            ph = VS_ACTIVE;
        else
            ph = VS_TAIL;
        return ph;
    endfunction

    assign line_end   = pix_ce && (hc == cfg.hper - 1'b1);
    assign frame_wrap = line_end && (vc == cfg.vper - 1'b1);

    // next-state: FRAME_WRAP uses the incoming timing, LINE_STEP the current one
    always_comb begin
        st_d = st_q;
        if (frame_wrap)    st_d = phase_of('0, nxt);
        else if (line_end) st_d = phase_of(vc + 1'b1, cfg);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= phase_of('0, cfg);
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc  <= '0;
            vc  <= '0;
            vpx <= '0;
        end else begin
            if (pix_ce) begin
                if (line_end) begin
                    hc <= '0;
                    vc <= frame_wrap ? '0 : vc + 1'b1;
                end else begin
                    hc <= hc + 1'b1;
                end
            end
            if (frame_wrap)                vpx <= '0;
            else if (pix_ce && vpx != '1)  vpx <= vpx + 1'b1;
        end
    end

    // output process
    always_comb begin
        hs_raw = hc < {{(CNT_W-HWID_W){1'b0}}, cfg.hwid};
        vs_raw = cfg.vunit ? (vc < cfg.vwid) : (vpx < cfg.vwid);
        hwin   = (hc >= cfg.hwait) &&
                 ({1'b0, hc} < ({1'b0, cfg.hwait} + {1'b0, cfg.npix}));
        unique case (st_q)
            VS_ACTIVE:                  active = hwin;
            VS_PULSE, VS_WAIT, VS_TAIL: active = 1'b0;
            default:                    active = 1'b0;
        endcase
    end

    assign hsync = cfg.hpol ? hs_raw : ~hs_raw;
    assign vsync = cfg.vpol ? vs_raw : ~vs_raw;
    assign hc_o  = hc;
    assign vc_o  = vc;

    assert_hcount_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hper != '0) |-> (hc < cfg.hper));

    assert_vcount_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.vper != '0) |-> (vc < cfg.vper));

    assert_vsync_line_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.vunit && $past(cfg.vunit) && (vsync != $past(vsync))) |-> (hc == '0));

    assert_active_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((vc >= cfg.vwait) &&
                    ({1'b0, vc} < ({1'b0, cfg.vwait} + {1'b0, cfg.nline}))));

endmodule

// File: rtl/rtg_top.sv
module rtg_top
    import rtg_pkg::*;
#(
    parameter int unsigned P_HPER  = 800,
    parameter int unsigned P_HWID  = 96,
    parameter int unsigned P_VPER  = 525,
    parameter int unsigned P_VWID  = 2,
    parameter int unsigned P_HWAIT = 144,
    parameter int unsigned P_VWAIT = 33,
    parameter int unsigned P_NPIX  = 640,
    parameter int unsigned P_NLINE = 480,
    parameter bit          P_HPOL  = 1'b0,
    parameter bit          P_VPOL  = 1'b0,
    parameter bit          P_VUNIT = 1'b1,
    parameter int unsigned P_DIV   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              pix_ce,
    output logic              hsync,
    output logic              vsync,
    output logic              active,
    output logic [CNT_W-1:0]  pos_x,
    output logic [CNT_W-1:0]  pos_y
);

    localparam tcfg_t RST_CFG = '{
        hper:  CNT_W'(P_HPER),  hwid:  HWID_W'(P_HWID),
        vper:  CNT_W'(P_VPER),  vwid:  CNT_W'(P_VWID),
        hpol:  P_HPOL,          vpol:  P_VPOL,   vunit: P_VUNIT,
        hwait: CNT_W'(P_HWAIT), vwait: CNT_W'(P_VWAIT),
        npix:  CNT_W'(P_NPIX),  nline: CNT_W'(P_NLINE)
    };

    tcfg_t            shadow, work;
    logic [DIV_W-1:0] div_q;
    logic             gate_q, div_wr, frame_wrap;

    rtg_regs #(
        .RST_CFG  (RST_CFG),
        .RST_DIV  (DIV_W'(P_DIV)),
        .RST_GATE (1'b0)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .load   (frame_wrap),
        .shadow (shadow),
        .work   (work),
        .div_q  (div_q),
        .gate_q (gate_q),
        .div_wr (div_wr)
    );

    rtg_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_q   (div_q),
        .gate_q  (gate_q),
        .restart (div_wr),
        .pix_ce  (pix_ce)
    );

    rtg_raster u_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_ce     (pix_ce),
        .cfg        (work),
        .nxt        (shadow),
        .frame_wrap (frame_wrap),
        .hc_o       (pos_x),
        .vc_o       (pos_y),
        .hsync      (hsync),
        .vsync      (vsync),
        .active     (active)
    );

endmodule

// File: tb/rtg_top_tb_top.sv
module rtg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        pix_ce, hsync, vsync, active;
    logic [15:0] pos_x, pos_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rtg_top #(
        .P_HPER(20), .P_HWID(3), .P_VPER(8), .P_VWID(2),
        .P_HWAIT(5), .P_VWAIT(3), .P_NPIX(10), .P_NLINE(4),
        .P_HPOL(1'b0), .P_VPOL(1'b0), .P_VUNIT(1'b1), .P_DIV(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
        .active(active), .pos_x(pos_x), .pos_y(pos_y)
    );

    // reset words in register-map layout
    localparam logic [31:0] RW0 = {8'd3, 8'd0, 16'd20};
    localparam logic [31:0] RW1 = 32'd8;
    localparam logic [31:0] RW2 = {13'd0, 1'b1, 1'b0, 1'b0, 16'd2};
    localparam logic [31:0] RW3 = {16'd5, 16'd3};
    localparam logic [31:0] RW4 = {16'd4, 16'd10};

    // ---------------- reference model ----------------
    logic [31:0] m_sh [5];
    logic [31:0] m_wk [5];
    int m_div, m_dc, m_hc, m_vc, m_vpx;
    bit m_gate;

    function automatic int f_hper();  return int'(m_wk[0][15:0]);  endfunction
    function automatic int f_hwid();  return int'(m_wk[0][31:24]); endfunction
    function automatic int f_vper();  return int'(m_wk[1][15:0]);  endfunction
    function automatic int f_vwid();  return int'(m_wk[2][15:0]);  endfunction
    function automatic int f_hwait(); return int'(m_wk[3][31:16]); endfunction
    function automatic int f_vwait(); return int'(m_wk[3][15:0]);  endfunction
    function automatic int f_nline(); return int'(m_wk[4][31:16]); endfunction
    function automatic int f_npix();  return int'(m_wk[4][15:0]);  endfunction

    function automatic bit m_ce();
        return !m_gate && (m_div <= 1 || m_dc == m_div - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sh[0] = RW0; m_sh[1] = RW1; m_sh[2] = RW2; m_sh[3] = RW3; m_sh[4] = RW4;
            m_wk = m_sh;
            m_div = 1; m_gate = 1'b0; m_dc = 0;
            m_hc = 0; m_vc = 0; m_vpx = 0;
        end else begin
            bit ce;
            bit wrap;
            ce = m_ce();
            wrap = 1'b0;
            if (cfg_we && cfg_addr == 3'd5) m_dc = 0;
            else if (m_gate || m_div <= 1)  m_dc = 0;
            else if (m_dc == m_div - 1)     m_dc = 0;
            else                            m_dc = m_dc + 1;
            if (ce) begin
                if (m_hc == f_hper() - 1) begin
                    m_hc = 0;
                    if (m_vc == f_vper() - 1) begin
                        m_vc = 0; wrap = 1'b1;
                    end else m_vc = m_vc + 1;
                end else m_hc = m_hc + 1;
            end
            if (wrap) begin
                m_vpx = 0;
                m_wk = m_sh;
            end else if (ce && m_vpx != 65535) m_vpx = m_vpx + 1;
            if (cfg_we) begin
                if (cfg_addr < 3'd5) m_sh[cfg_addr] = cfg_wdata;
                else if (cfg_addr == 3'd5) begin
                    m_div = int'(cfg_wdata[7:0]);
                    m_gate = cfg_wdata[31];
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmp(input string req);
        bit hs, vs, ac;
        hs = (m_hc < f_hwid());
        hs = m_wk[2][16] ? hs : !hs;
        vs = m_wk[2][18] ? (m_vc < f_vwid()) : (m_vpx < f_vwid());
        vs = m_wk[2][17] ? vs : !vs;
        ac = (m_hc >= f_hwait()) && (m_hc < f_hwait() + f_npix()) &&
             (m_vc >= f_vwait()) && (m_vc < f_vwait() + f_nline());
        chk(req, "pos_x", int'(pos_x), m_hc);
        chk(req, "pos_y", int'(pos_y), m_vc);
        chk(req, "hsync", int'(hsync), int'(hs));
        chk(req, "vsync", int'(vsync), int'(vs));
        chk(req, "active", int'(active), int'(ac));
        chk(req, "pix_ce", int'(pix_ce), int'(m_ce()));
    endtask

    task automatic tick(input string req);
        @(negedge clk);
        cmp(req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(req);
        cfg_we = 1'b0;
    endtask

    task automatic to_frame_start(input string req);
        for (int i = 0; i < 2000; i++) begin
            tick(req);
            if (pos_x == 16'd0 && pos_y == 16'd0) break;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R10", "reset pos_x", int'(pos_x), 0);
        chk("R10", "reset pos_y", int'(pos_y), 0);
        chk("R10", "reset hsync (active-low, asserted)", int'(hsync), 0);
        chk("R10", "reset vsync (active-low, asserted)", int'(vsync), 0);
        chk("R10", "reset active", int'(active), 0);
        chk("R10", "reset pix_ce", int'(pix_ce), 1);
        cmp("R10");
    endtask

    task automatic t_base();
        int n_act, n_hs, n_vs;
        n_act = 0; n_hs = 0; n_vs = 0;
        for (int i = 0; i < 160; i++) begin
            tick("R1 R2 R3 R4 R6");
            n_act += int'(active);
            n_hs  += int'(!hsync);
            n_vs  += int'(!vsync);
        end
        chk("R6", "active cycles per frame", n_act, 40);
        chk("R2", "hsync asserted cycles per frame", n_hs, 24);
        chk("R4", "vsync asserted cycles per frame", n_vs, 40);
        for (int i = 0; i < 160; i++) tick("R1 R3");
    endtask

    task automatic t_pixel_vsync();
        int n_vs;
        n_vs = 0;
        wr(3'd2, {13'd0, 1'b0, 1'b0, 1'b0, 16'd7}, "R5");
        to_frame_start("R5");
        n_vs += int'(!vsync);
        for (int i = 0; i < 159; i++) begin
            tick("R5");
            n_vs += int'(!vsync);
        end
        chk("R5", "pixel-unit vsync cycles per frame", n_vs, 7);
        wr(3'd2, RW2, "R4");
        to_frame_start("R4");
    endtask

    task automatic t_div();
        int n;
        wr(3'd5, 32'd3, "R8");
        n = 0;
        for (int i = 0; i < 30; i++) begin
            tick("R8");
            n += int'(pix_ce);
        end
        chk("R8", "pix_ce count over 30 clocks at divide-by-3", n, 10);
        wr(3'd5, 32'd0, "R8");
        n = 0;
        for (int i = 0; i < 10; i++) begin
            tick("R8");
            n += int'(pix_ce);
        end
        chk("R8", "pix_ce count over 10 clocks at divider 0", n, 10);
        wr(3'd5, 32'd1, "R8");
    endtask

    task automatic t_gate();
        logic [15:0] sx, sy;
        int n;
        wr(3'd5, 32'h8000_0001, "R9");
        sx = pos_x; sy = pos_y; n = 0;
        for (int i = 0; i < 20; i++) begin
            tick("R9");
            n += int'(pix_ce);
        end
        chk("R9", "pix_ce count while gated", n, 0);
        chk("R9", "pos_x held while gated", int'(pos_x), int'(sx));
        chk("R9", "pos_y held while gated", int'(pos_y), int'(sy));
        wr(3'd5, 32'd1, "R9");
        for (int i = 0; i < 5; i++) tick("R9");
    endtask

    task automatic t_unused();
        int mx;
        wr(3'd6, 32'h0001_0004, "R11");
        wr(3'd7, 32'hFFFF_FFFF, "R11");
        to_frame_start("R11");
        mx = 0;
        for (int i = 0; i < 160; i++) begin
            tick("R11");
            if (int'(pos_x) > mx) mx = int'(pos_x);
        end
        chk("R11", "line length after unused writes", mx, 19);
    endtask

    task automatic t_frame_sync();
        int mx;
        for (int i = 0; i < 400; i++) begin
            tick("R7");
            if (pos_x == 16'd1 && pos_y == 16'd2) break;
        end
        wr(3'd2, RW2 | 32'h0001_0000, "R7");
        wr(3'd0, {8'd3, 8'd0, 16'd12}, "R7");
        chk("R7", "hsync keeps old polarity inside frame", int'(hsync), 1);
        mx = int'(pos_x);
        for (int i = 0; i < 400; i++) begin
            tick("R7");
            if (pos_x == 16'd0 && pos_y == 16'd0) break;
            if (int'(pos_x) > mx) mx = int'(pos_x);
        end
        chk("R7", "old line length kept until wrap", mx, 19);
        chk("R7", "new hsync polarity at frame start", int'(hsync), 1);
        mx = 0;
        for (int i = 0; i < 96; i++) begin
            tick("R7");
            if (int'(pos_x) > mx) mx = int'(pos_x);
        end
        chk("R7", "new line length after wrap", mx, 11);
    endtask

    // ---------------- sequencing ----------------
    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base();
        t_pixel_vsync();
        t_div();
        t_gate();
        t_unused();
        t_frame_sync();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule